// File: doc/BRIEF.md
# Nested-Level Round-Robin Bus Arbiter with Repeat Grants

This block decides which of up to eight bus masters owns the address bus for the next tenure. Every master carries a two-bit priority level. Inside one level, the requesting masters take turns in round-robin order. Each level above the lowest also owns one extra turn, placed after its last master, that passes the decision down to the level beneath it. A low-level master therefore always gets a fixed, predictable share of the bus, even when the higher levels are busy.

A master that already holds the bus can ask to keep it for back-to-back transfers. It does this by raising its repeat line together with its request. Such a repeat wins over every other requester, but two things can cancel it. An address-retry indication on the current tenure cancels it. So does a programmable consecutive-repeat budget. One designated bridge master counts its repeats against its own budget, which is set separately from the budget shared by all other masters.

The grant is a registered one-hot vector. It is re-evaluated only in a cycle where the tenure-done strobe is high, and the new grant appears after the following clock edge.

Top module: `nest_rr_arbiter`

## Requirements
- R1: After reset the grant is all-zero and every level's rotation starts at its lowest-indexed slot.
- R2: The grant is one-hot or all-zero. It changes only on the clock edge that samples the tenure-done strobe high.
- R3: Master i takes its level from bits [2i+1:2i] of the priority bus, with level 3 the highest. Only a requesting master can be granted.
- R4: Within a level, slots are visited in ascending master index, starting just after the slot last chosen. The pass-down slot comes after the highest index. With master 6 at level 3, masters 4 and 5 at level 2, masters 0 and 3 at level 1, and masters 1 and 2 at level 0, all requesting, the grant sequence from reset starts 6,4,6,5,6,0. Over 360 grants the counts are 180, 60, 60, 20, 20, 10 and 10 for masters 6, 4, 5, 0, 3, 1 and 2.
- R5: A pass-down slot is skipped when nothing below its level is requesting, and levels without requesters are skipped. A tenure with any request always yields a grant, and a tenure with no request yields all-zero.
- R6: When the owner requests with repeat, it is granted again, even if a higher-level master is requesting.
- R7: While the retry input is high at the tenure-done strobe, a repeat is refused and normal arbitration decides the grant.
- R8: After a normal grant, a non-bridge master receives at most `rpt_limit` consecutive repeat grants. A limit of 0 disables repeats.
- R9: The bridge master (index BRIDGE, default 7) counts its repeats against `bridge_limit` instead of `rpt_limit`.
- R10: Repeat grants do not move any rotation. After a run of repeats, normal arbitration continues where it left off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NM | Per-master bus request |
| rpt | input | NM | Per-master repeat request |
| prio | input | 2*NM | Per-master level, two bits each |
| rpt_limit | input | CW | Repeat budget for non-bridge masters |
| bridge_limit | input | CW | Repeat budget for the bridge master |
| retry | input | 1 | Current address tenure is being retried |
| tenure_done | input | 1 | Arbitration strobe, one cycle per tenure |
| gnt | output | NM | One-hot registered grant |

## Verification
The hardest situation to reach is the point where a repeat budget runs out while a higher-level master keeps requesting. Reaching it needs a low-level master to win normally first, then hold the bus through exactly the budgeted number of repeats. The stimulus starts the sequence with only the low master requesting. After that first grant it adds the higher-level requester and holds repeat high on the owner. Each tenure is then checked one by one, so the single cycle where the grant finally moves is observed. Separate scenarios do the same for the bridge's own budget, for a zero budget, and under retry.

// File: rtl/nest_arb_pkg.sv
package nest_arb_pkg;
    localparam int LVLS  = 4;
    localparam int LVL_W = 2;
endpackage

// File: rtl/nest_rr_pick.sv
module nest_rr_pick #(
    parameter int NS = 9,
    localparam int PW = $clog2(NS)
) (
    input  logic [NS-1:0] cand,
    input  logic [PW-1:0] ptr,
    output logic [PW-1:0] pick,
    output logic          valid
);
    always_comb begin
        pick  = '0;
        valid = 1'b0;
        for (int k = 0; k < NS; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= NS) idx = idx - NS;
            if (!valid && cand[idx]) begin
                valid = 1'b1;
                pick  = PW'(idx);
            end
        end
    end
endmodule

// File: rtl/nest_rpt_cnt.sv
module nest_rpt_cnt #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          nz
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign nz = (cnt_q != '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) dec |-> nz); // R8
    AST_LOAD_DEC_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(load && dec)); // R8
endmodule

// File: rtl/nest_rr_arbiter.sv
module nest_rr_arbiter
    import nest_arb_pkg::*;
#(
    parameter int NM     = 8,
    parameter int CW     = 4,
    parameter int BRIDGE = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NM-1:0]       req,
    input  logic [NM-1:0]       rpt,
    input  logic [LVL_W*NM-1:0] prio,
    input  logic [CW-1:0]       rpt_limit,
    input  logic [CW-1:0]       bridge_limit,
    input  logic                retry,
    input  logic                tenure_done,
    output logic [NM-1:0]       gnt
);
    localparam int NS = NM + 1;
    localparam int PW = $clog2(NS);

    typedef struct packed {
        logic [NM-1:0]            gnt;
        logic [LVLS-1:0][PW-1:0]  ptr;
    } st_t;

    st_t st_d, st_q;

    logic [LVLS-1:0][NM-1:0] lvl_req;
    logic [LVLS-1:0]         below;
    logic [LVLS-1:0][NS-1:0] cand;
    logic [LVLS-1:0][PW-1:0] pick;
    logic [LVLS-1:0]         pvld;

    always_comb begin
        for (int l = 0; l < LVLS; l++)
            for (int i = 0; i < NM; i++)
                lvl_req[l][i] = req[i] && (prio[LVL_W*i +: LVL_W] == LVL_W'(l));
        below[0] = 1'b0;
        for (int l = 1; l < LVLS; l++)
            below[l] = below[l-1] | (|lvl_req[l-1]);
        for (int l = 0; l < LVLS; l++)
            cand[l] = {below[l], lvl_req[l]};
    end

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        nest_rr_pick #(.NS(NS)) u_pick (
            .cand  (cand[l]),
            .ptr   (st_q.ptr[l]),
            .pick  (pick[l]),
            .valid (pvld[l])
        );
    end

    logic gen_nz, br_nz;
    logic gen_load, br_load, gen_dec, br_dec;

    nest_rpt_cnt #(.CW(CW)) u_cnt_gen (
        .clk(clk), .rst_n(rst_n), .load(gen_load), .load_val(rpt_limit),
        .dec(gen_dec), .nz(gen_nz)
    );
    nest_rpt_cnt #(.CW(CW)) u_cnt_br (
        .clk(clk), .rst_n(rst_n), .load(br_load), .load_val(bridge_limit),
        .dec(br_dec), .nz(br_nz)
    );

    logic                    own_br, rpt_ok, win_vld, descend;
    logic [PW-1:0]           win;
    logic [LVLS-1:0][PW-1:0] ptr_n;

    always_comb begin
        own_br  = st_q.gnt[BRIDGE];
        rpt_ok  = (|(st_q.gnt & req & rpt)) && !retry && (own_br ? br_nz : gen_nz);

        ptr_n   = st_q.ptr;
        win     = '0;
        win_vld = 1'b0;
        descend = 1'b1;
        for (int l = LVLS-1; l >= 0; l--) begin
            if (descend && pvld[l]) begin
                if (pick[l] == PW'(NM)) begin
                    ptr_n[l] = '0;
                end else begin
                    ptr_n[l] = pick[l] + 1'b1;
                    win      = pick[l];
                    win_vld  = 1'b1;
                    descend  = 1'b0;
                end
            end
        end

        st_d     = st_q;
        gen_load = 1'b0;
        br_load  = 1'b0;
        gen_dec  = 1'b0;
        br_dec   = 1'b0;
        if (tenure_done) begin
            if (rpt_ok) begin
                gen_dec = !own_br;
                br_dec  = own_br;
            end else begin
                st_d.gnt = '0;
                st_d.ptr = ptr_n;
                if (win_vld) begin
                    st_d.gnt[win] = 1'b1;
                    br_load  = (win == PW'(BRIDGE));
                    gen_load = (win != PW'(BRIDGE));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt = st_q.gnt;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R2
    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tenure_done |=> $stable(gnt)); // R2
    AST_GNT_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n) tenure_done |=> ((gnt & $past(req)) == gnt)); // R3
    AST_REQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n) (tenure_done && |req) |=> |gnt); // R5
    AST_REPEAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tenure_done && !retry && |(gnt & req & rpt) && (gnt[BRIDGE] ? br_nz : gen_nz)) |=> $stable(gnt)); // R6
endmodule

// File: tb/sim_nest_rr_arbiter.sv
module sim_nest_rr_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0, rpt = '0;
    logic [15:0] prio = '0;
    logic [3:0]  rpt_limit = '0, bridge_limit = '0;
    logic        retry = 1'b0, tenure_done = 1'b0;
    logic [7:0]  gnt;
    int n_cmp = 0, n_bad = 0;

    always #10 clk = ~clk;

    nest_rr_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .rpt(rpt), .prio(prio),
        .rpt_limit(rpt_limit), .bridge_limit(bridge_limit), .retry(retry),
        .tenure_done(tenure_done), .gnt(gnt)
    );

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt=%b expected %b", rq, act, exp);
        end
    endtask

    task automatic chk_int(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: count=%0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; rpt = '0; retry = 1'b0; tenure_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic setp(input int m, input int l);
        prio[2*m +: 2] = l[1:0];
    endtask

    task automatic tenure();
        tenure_done = 1'b1;
        @(negedge clk);
        tenure_done = 1'b0;
    endtask

    function automatic logic [7:0] oh(input int m);
        return 8'b1 << m;
    endfunction

    task automatic std_prio();
        prio = '0;
        setp(6, 3); setp(4, 2); setp(5, 2); setp(0, 1); setp(3, 1);
        setp(1, 0); setp(2, 0); setp(7, 0);
    endtask

    task automatic t_reset_hold();
        do_reset();
        chk("R1 reset grant", gnt, 8'h00);
        std_prio();
        req = 8'h7F;
        repeat (3) @(negedge clk);
        chk("R2 no strobe no change", gnt, 8'h00);
        tenure();
        chk("R2 strobe grants", gnt, oh(6));
        repeat (3) @(negedge clk);
        chk("R2 hold between strobes", gnt, oh(6));
        req = '0;
        tenure();
        chk("R5 no request gives zero", gnt, 8'h00);
    endtask

    task automatic t_fraction();
        int cnt[8];
        int seq[6] = '{6, 4, 6, 5, 6, 0};
        int ok1;
        do_reset();
        std_prio();
        req = 8'h7F;
        for (int i = 0; i < 8; i++) cnt[i] = 0;
        ok1 = 1;
        for (int n = 0; n < 360; n++) begin
            tenure();
            if (n < 6) chk("R4 order from reset", gnt, oh(seq[n]));
            if (!$onehot(gnt)) ok1 = 0;
            for (int i = 0; i < 8; i++) if (gnt[i]) cnt[i]++;
        end
        chk_int("R2 always one-hot", ok1, 1);
        chk_int("R4 share m6", cnt[6], 180);
        chk_int("R4 share m4", cnt[4], 60);
        chk_int("R4 share m5", cnt[5], 60);
        chk_int("R4 share m0", cnt[0], 20);
        chk_int("R4 share m3", cnt[3], 20);
        chk_int("R4 share m1", cnt[1], 10);
        chk_int("R4 share m2", cnt[2], 10);
        chk_int("R3 idle m7", cnt[7], 0);
    endtask

    task automatic t_skip();
        do_reset();
        std_prio();
        req = oh(1);
        for (int n = 0; n < 4; n++) begin
            tenure();
            chk("R5 lone low master", gnt, oh(1));
        end
    endtask

    task automatic t_repeat();
        do_reset();
        std_prio();
        rpt_limit = 4'd3; bridge_limit = 4'd9;
        req = oh(0);
        tenure();
        chk("R6 first normal grant", gnt, oh(0));
        req = oh(0) | oh(6); rpt = oh(0);
        for (int n = 0; n < 3; n++) begin
            tenure();
            chk("R6 repeat beats higher level", gnt, oh(0));
        end
        tenure();
        chk("R8 budget expired", gnt, oh(6));
    endtask

    task automatic t_limit0();
        do_reset();
        std_prio();
        rpt_limit = 4'd0; bridge_limit = 4'd9;
        req = oh(0);
        tenure();
        req = oh(0) | oh(6); rpt = oh(0);
        tenure();
        chk("R8 zero budget no repeat", gnt, oh(6));
    endtask

    task automatic t_retry();
        do_reset();
        std_prio();
        rpt_limit = 4'd3;
        req = oh(0);
        tenure();
        req = oh(0) | oh(6); rpt = oh(0); retry = 1'b1;
        tenure();
        chk("R7 retry refuses repeat", gnt, oh(6));
        retry = 1'b0;
    endtask

    task automatic t_bridge();
        do_reset();
        std_prio();
        rpt_limit = 4'd1; bridge_limit = 4'd4;
        req = oh(7);
        tenure();
        chk("R9 bridge normal grant", gnt, oh(7));
        req = oh(7) | oh(6); rpt = oh(7);
        for (int n = 0; n < 4; n++) begin
            tenure();
            chk("R9 bridge own budget", gnt, oh(7));
        end
        tenure();
        chk("R9 bridge budget expired", gnt, oh(6));
    endtask

    task automatic t_rotation();
        do_reset();
        std_prio();
        rpt_limit = 4'd2;
        req = oh(6) | oh(4) | oh(5);
        tenure();
        chk("R10 start", gnt, oh(6));
        rpt = oh(6);
        tenure();
        chk("R10 repeat 1", gnt, oh(6));
        tenure();
        chk("R10 repeat 2", gnt, oh(6));
        tenure();
        chk("R10 rotation resumes", gnt, oh(4));
        rpt = '0;
        tenure();
        chk("R10 next top", gnt, oh(6));
        tenure();
        chk("R10 next level2", gnt, oh(5));
    endtask

    initial begin
        t_reset_hold();
        t_fraction();
        t_skip();
        t_repeat();
        t_limit0();
        t_retry();
        t_bridge();
        t_rotation();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule